// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block is a purely combinational unsigned adder. It takes two operands and an incoming carry and returns their sum together with the carry out of the top bit. No carry ripples from one part of the operand to the next. The operand is cut into equal slices, four bits wide by default. Each slice forms per-bit generate and propagate terms, and from them one generate and one propagate term for the whole slice. A second lookahead stage, built from the same logic, combines the slice terms with the incoming carry. It produces the carry into every slice and the final carry out as flat sums of products.

Each slice then forms its own sum bits. It does this with an in-slice lookahead fed by the carry that the second stage hands it. The default width is 16 bits in four slices. Both the width and the slice width are parameters. The block has no clock and no state, so a datapath can place it between its own registers.

Top module: `lookahead_adder`

## Requirements
- R1: For every pair of operands and either value of `cin`, the concatenation {`cout`, `sum`} equals the unsigned value `a` + `b` + `cin`, taken as WIDTH+1 bits.
- R2: A bit position where both operand bits are 1 produces a carry into the next position whatever carry it receives. A position where exactly one bit is 1 passes its incoming carry on.
- R3: The carry into slice 0 is `cin`. The carry into each higher slice comes from the second-level lookahead built on slice generate/propagate terms, and it matches the carry that the slice below would compute on its own.
- R4: `cout` equals the generate term over the whole operand OR'ed with (the propagate term over the whole operand AND `cin`).
- R5: When every bit position propagates (a_i OR b_i is 1 for all i) and `cin` is 1, `cout` is 1. For all-ones plus zero plus a carry-in of 1, `sum` is 0.
- R6: When no position generates (a AND b is 0), `cout` equals `cin` AND (every bit propagates). With `cin` = 0 in that case, `sum` equals a OR b.
- R7: A carry generated in the top bit of one slice appears in the lowest sum bit of the next slice, for example 0x000F + 0x0001 = 0x0010.
- R8: The outputs depend only on the present inputs. A new input value is fully reflected at the outputs within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
Every result of this block is due zero clock cycles after its stimulus, because no register lies between the operands and `sum`/`cout`. The bench changes the inputs on the falling edge of its clock and reads the outputs 1 ns later, well before the next rising edge. Each check therefore sees settled values from the stimulus it applied and never from an earlier one. For R8 the bench applies two different operand pairs inside one clock period and checks both without any edge in between. The expected value is always the bench's own wide addition of the operands and the carry.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Compressed carry behaviour of a run of bit positions.
  typedef struct packed {
    logic prop;  // a carry entering the run leaves it
    logic gen;   // the run produces a carry on its own
  } pg_t;

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic [W-1:0] prop,
  output logic [W-1:0] gen
);

  // Per-position terms: generate when both bits are set, propagate when either is.
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign gen[i]  = op_x[i] & op_y[i];
      assign prop[i] = op_x[i] | op_y[i];
    end
  endgenerate

endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] prop,
  input  logic [N-1:0] gen,
  input  logic         c_base,
  output logic [N-1:0] c_pos,   // carry entering each position; c_pos[0] = c_base
  output logic         c_last,  // carry leaving position N-1
  output logic         blk_p,
  output logic         blk_g
);

  logic [N:0] carry;

  // Every carry is a flat sum of products over the terms below it and the
  // base carry; no carry term is built from another carry term.
  always_comb begin
    for (int j = 0; j <= N; j++) begin
      logic acc;
      logic chain;
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        logic term;
        term = gen[k];
        for (int m = k + 1; m < j; m++) begin
          term = term & prop[m];
        end
        acc = acc | term;
      end
      chain = c_base;
      for (int m = 0; m < j; m++) begin
        chain = chain & prop[m];
      end
      carry[j] = acc | chain;
    end
  end

  // Block terms: generate without the base carry, propagate as a full AND.
  always_comb begin
    logic bg;
    bg = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic term;
      term = gen[k];
      for (int m = k + 1; m < N; m++) begin
        term = term & prop[m];
      end
      bg = bg | term;
    end
    blk_g = bg;
    blk_p = &prop;
  end

  assign c_pos  = carry[N-1:0];
  assign c_last = carry[N];

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] op_x,
  input  logic [GW-1:0] op_y,
  input  logic          c_enter,
  output logic [GW-1:0] part_sum,
  output pg_t           grp_pg,
  output logic          c_local
);

  logic [GW-1:0] bp;
  logic [GW-1:0] bg;
  logic [GW-1:0] bc;
  logic          sp;
  logic          sg;

  cla_bit_pg #(.W(GW)) u_pg (
    .op_x (op_x),
    .op_y (op_y),
    .prop (bp),
    .gen  (bg)
  );

  cla_lookahead #(.N(GW)) u_la (
    .prop   (bp),
    .gen    (bg),
    .c_base (c_enter),
    .c_pos  (bc),
    .c_last (c_local),
    .blk_p  (sp),
    .blk_g  (sg)
  );

  assign part_sum    = op_x ^ op_y ^ bc;
  assign grp_pg.prop = sp;
  assign grp_pg.gen  = sg;

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import cla_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GRP_W = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NGRP = WIDTH / GRP_W;

  generate
    if (NGRP * GRP_W != WIDTH || NGRP < 1) begin : g_bad_cfg
      $error("WIDTH must be a positive multiple of GRP_W");
    end
  endgenerate

  logic [NGRP-1:0] grp_p;
  logic [NGRP-1:0] grp_g;
  logic [NGRP-1:0] grp_cin;
  logic [NGRP-1:0] grp_cout_local;
  logic            all_p;
  logic            all_g;

  genvar k;
  generate
    for (k = 0; k < NGRP; k++) begin : g_grp
      pg_t slice_pg;
      cla_group #(.GW(GRP_W)) u_grp (
        .op_x     (a[k*GRP_W +: GRP_W]),
        .op_y     (b[k*GRP_W +: GRP_W]),
        .c_enter  (grp_cin[k]),
        .part_sum (sum[k*GRP_W +: GRP_W]),
        .grp_pg   (slice_pg),
        .c_local  (grp_cout_local[k])
      );
      assign grp_p[k] = slice_pg.prop;
      assign grp_g[k] = slice_pg.gen;
    end
  endgenerate

  // Second level: slice carries and the final carry come from slice terms only.
  cla_lookahead #(.N(NGRP)) u_lvl2 (
    .prop   (grp_p),
    .gen    (grp_g),
    .c_base (cin),
    .c_pos  (grp_cin),
    .c_last (cout),
    .blk_p  (all_p),
    .blk_g  (all_g)
  );

endmodule

// File: rtl/lookahead_adder_chk.sv
module lookahead_adder_chk #(
  parameter int WIDTH = 16,
  parameter int GRP_W = 4,
  localparam int NGRP = WIDTH / GRP_W
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NGRP-1:0]  grp_cin,
  input logic [NGRP-1:0]  grp_cout_local,
  input logic             all_p,
  input logic             all_g
);

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      assert_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
        else $error("R1: sum mismatch");
      assert_base_carry_R3: assert (grp_cin[0] == cin)
        else $error("R3: slice 0 carry differs from cin");
      for (int k = 1; k < NGRP; k++) begin
        assert_slice_carry_R3: assert (grp_cin[k] == grp_cout_local[k-1])
          else $error("R3: lookahead carry disagrees with slice below");
      end
      assert_top_carry_R3: assert (cout == grp_cout_local[NGRP-1])
        else $error("R3: top slice carry disagrees with cout");
      assert_cout_R4: assert (cout == (all_g | (all_p & cin)))
        else $error("R4: cout disagrees with whole-word terms");
      if ((&(a | b)) && cin) begin
        assert_full_prop_R5: assert (cout)
          else $error("R5: full propagate lost the carry");
      end
      if ((a & b) == '0) begin
        assert_no_gen_R6: assert (cout == (cin & (&(a | b))))
          else $error("R6: carry out without a generate");
        if (!cin) begin
          assert_no_gen_sum_R6: assert (sum == (a | b))
            else $error("R6: sum differs from OR with no carries");
        end
      end
    end
  end

endmodule

bind lookahead_adder lookahead_adder_chk #(
  .WIDTH (WIDTH),
  .GRP_W (GRP_W)
) u_chk (
  .a              (a),
  .b              (b),
  .cin            (cin),
  .sum            (sum),
  .cout           (cout),
  .grp_cin        (grp_cin),
  .grp_cout_local (grp_cout_local),
  .all_p          (all_p),
  .all_g          (all_g)
);

// File: tb/test_lookahead_adder.sv
module test_lookahead_adder;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  lookahead_adder #(.WIDTH(W), .GRP_W(4)) i_lookahead_adder (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  // Compare outputs with the bench's own wide addition.
  task automatic compare(input string tag);
    logic [W:0] exp;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h",
               tag, a, b, cin, {cout, sum}, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns later (zero-cycle latency).
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic c, input string tag);
    @(negedge clk);
    a = x; b = y; cin = c;
    #1;
    compare(tag);
  endtask

  task automatic expect_bits(input string tag, input logic [W:0] exp);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, {cout, sum}, exp);
    end
  endtask

  task automatic t_reset_state;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    expect_bits("R1 idle zero", '0);
  endtask

  task automatic t_generate;  // R2
    apply(16'h0100, 16'h0100, 1'b0, "R2 generate");
    expect_bits("R2 generate", 17'h00200);
    apply(16'h8000, 16'h8000, 1'b0, "R2 generate top");
    expect_bits("R2 generate top", 17'h10000);
    apply(16'h0010, 16'h0000, 1'b1, "R2 single propagate");
    apply(16'h0001, 16'h0000, 1'b1, "R2 pass carry");
    expect_bits("R2 pass carry", 17'h00002);
  endtask

  task automatic t_boundary;  // R7, R3
    apply(16'h000F, 16'h0001, 1'b0, "R7 slice0 to slice1");
    expect_bits("R7 slice0 to slice1", 17'h00010);
    apply(16'h00F0, 16'h0010, 1'b0, "R7 slice1 to slice2");
    apply(16'h0F00, 16'h0100, 1'b0, "R7 slice2 to slice3");
    apply(16'h0FFF, 16'h0000, 1'b1, "R3 skip three slices");
    expect_bits("R3 skip three slices", 17'h01000);
    apply(16'h00FF, 16'h0F01, 1'b0, "R3 mixed slices");
  endtask

  task automatic t_full_prop;  // R5
    apply(16'hFFFF, 16'h0000, 1'b1, "R5 all ones plus cin");
    expect_bits("R5 all ones plus cin", 17'h10000);
    apply(16'h5555, 16'hAAAA, 1'b1, "R5 alternating plus cin");
    expect_bits("R5 alternating plus cin", 17'h10000);
    apply(16'hFFFF, 16'h0000, 1'b0, "R5 all ones no cin");
    expect_bits("R5 all ones no cin", 17'h0FFFF);
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R5 max operands");
  endtask

  task automatic t_no_generate;  // R6, R4
    apply(16'h0F0F, 16'h7070, 1'b1, "R6 no generate cin");
    expect_bits("R6 no generate cin", 17'h07F80);
    apply(16'h1234, 16'h4842, 1'b0, "R6 sum is OR");
    expect_bits("R6 sum is OR", {1'b0, 16'h5A76});
    apply(16'h00FF, 16'hFF00, 1'b0, "R4 propagate only no cin");
    expect_bits("R4 propagate only no cin", 17'h0FFFF);
  endtask

  task automatic t_same_cycle;  // R8
    @(negedge clk);
    a = 16'h1111; b = 16'h2222; cin = 1'b0;
    #0.5;
    compare("R8 first value");
    a = 16'hF0F0; b = 16'h0F10; cin = 1'b1;
    #0.5;
    compare("R8 second value same period");
  endtask

  task automatic t_sweep;  // R1
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      apply(s[15:0], s[31:16], s[7] ^ s[22], "R1 sweep");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_generate();
    t_boundary();
    t_full_prop();
    t_no_generate();
    t_same_cycle();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule